// File: doc/BRIEF.md
# Multi-Mode Window Watchdog

This block supervises the software running on a host processor. Each write to the watchdog control register counts as a service strobe. The same write carries a 3-bit period selector and a watchdog-mode bit, and the block keeps both. The watchdog mode it runs in depends on two things: the system operating mode, which the surrounding power sequencer supplies, and the stored mode bit. The three watchdog modes are window, timeout and off.

In timeout mode the software must service the watchdog at least once per period. In window mode it must also wait until the first half of the period has passed. A missed period produces a reset request with an overflow cause. A service strobe that comes too early in window mode produces a reset request with an early cause. Time is counted in ticks of an external prescaled tick input. The block does not shape the reset pulse and does not sequence the system modes.

Top module: `mmwd_top`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0, the stored mode bit is 0, and the stored period code is 3'b100, which selects a period of BASE_TICKS ticks.
- R2: The period in ticks is (BASE_TICKS << code) >> 4 for code 0 to 7. For example, with BASE_TICKS = 16, code 5 gives 32 ticks, code 2 gives 4 ticks and code 0 gives 1 tick.
- R3: The `sys_mode` encoding is 0 off, 1 standby, 2 normal, 3 sleep, 4 overtemperature, and 5 to 7 count as off. Window mode applies when the system is in normal and the mode bit is 0. Timeout mode applies when the system is in normal and the mode bit is 1, or in standby and the mode bit is 0. In timeout mode a strobe never causes a fault.
- R4: The watchdog is off, and never raises `rst_req`, when the system is in off, sleep, overtemperature or an undefined code, or in standby with the mode bit at 1.
- R5: In window mode, a strobe with an unchanged code and mode bit, arriving while fewer than half the period's ticks have elapsed, raises `rst_req` with `rst_cause` = 1 in the next cycle and restarts the period.
- R6: If the period completes with no strobe, `rst_req` rises with `rst_cause` = 0 in the cycle after the tick that completes it, and a new period starts. If a tick and a strobe arrive together, the strobe takes priority.
- R7: An accepted strobe restarts the period without a request. A strobe is accepted in window mode once at least half the period has elapsed, and at any time in timeout mode.
- R8: A write that changes the period code or the mode bit restarts the period from zero, even in the first half of a window, and raises no request.
- R9: A change of the effective watchdog mode restarts the period from zero and raises no request in that cycle.
- R10: `rst_req` is a single-cycle pulse for each fault. In the cycle after a request it is 0 again unless a new fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled time-base strobe |
| sys_mode | input | 3 | System operating mode code |
| wr_en | input | 1 | Control register write, which is also the service strobe |
| wr_period | input | 3 | Period code carried by the write |
| wr_wmode | input | 1 | Watchdog-mode bit carried by the write |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 1 | Cause of the request: 1 for an early strobe, 0 for an overflow |

## Verification
The bench aims at the boundary between the first and second halves of a window. A design that gets this boundary wrong either resets a correctly timed strobe or lets an early one pass. It also covers writes that change the code or mode bit during the forbidden half; a design that treats these as plain strobes would raise a false early fault. It measures the overflow latency at several codes, including code 0, where the window half is empty; an off-by-one in the counter shows up as a period one tick too long or too short. Finally, it switches the system between modes mid-period and holds the watchdog in every off state, where a missed restart would fire early and a leaky off state would raise a request.

// File: rtl/mmwd_pkg.sv
package mmwd_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned NCODES  = 1 << CODE_W;
   localparam int unsigned REF_CODE = 4;   // code selecting BASE_TICKS

   typedef enum logic [2:0] {
      SYS_OFF      = 3'd0,
      SYS_STANDBY  = 3'd1,
      SYS_NORMAL   = 3'd2,
      SYS_SLEEP    = 3'd3,
      SYS_OVERTEMP = 3'd4
   } sys_mode_e;

   typedef enum logic [1:0] {
      WD_OFF     = 2'd0,
      WD_TIMEOUT = 2'd1,
      WD_WINDOW  = 2'd2
   } wd_mode_e;

   localparam logic CAUSE_OVERFLOW = 1'b0;
   localparam logic CAUSE_EARLY    = 1'b1;

endpackage

// File: rtl/mmwd_mode_dec.sv
module mmwd_mode_dec
   import mmwd_pkg::*;
(
   input  logic [2:0] sys_mode,
   input  logic       wmode,
   output wd_mode_e   mode
);
   always_comb begin
      unique case (sys_mode)
         SYS_NORMAL:  mode = wmode ? WD_TIMEOUT : WD_WINDOW;
         SYS_STANDBY: mode = wmode ? WD_OFF : WD_TIMEOUT;
         default:     mode = WD_OFF;
      endcase
   end
endmodule

// File: rtl/mmwd_period_lut.sv
module mmwd_period_lut
   import mmwd_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 16,
   parameter int unsigned CNT_W      = 8
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  half
);
   logic [CNT_W-1:0] lut [NCODES];

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam int unsigned TICKS = (BASE_TICKS << c) >> REF_CODE;
      assign lut[c] = CNT_W'(TICKS);
   end

   assign period = lut[code];
   assign half   = period >> 1;
endmodule

// File: rtl/mmwd_timer.sv
module mmwd_timer
   import mmwd_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  wd_mode_e         mode,
   input  logic             mode_chg,
   input  logic             wr_en,
   input  logic             cfg_chg,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] half,
   output logic [CNT_W-1:0] cnt,
   output logic             req,
   output logic             cause
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         req   <= 1'b0;
         cause <= CAUSE_OVERFLOW;
      end else begin
         req <= 1'b0;
         if (mode == WD_OFF || mode_chg) begin
            cnt <= '0;
         end else if (wr_en) begin
            cnt <= '0;
            if (!cfg_chg && mode == WD_WINDOW && cnt < half) begin
               req   <= 1'b1;
               cause <= CAUSE_EARLY;
            end
         end else if (tick) begin
            if (cnt >= period - CNT_W'(1)) begin
               cnt   <= '0;
               req   <= 1'b1;
               cause <= CAUSE_OVERFLOW;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/mmwd_top.sv
module mmwd_top
   import mmwd_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [2:0] sys_mode,
   input  logic       wr_en,
   input  logic [2:0] wr_period,
   input  logic       wr_wmode,
   output logic       rst_req,
   output logic       rst_cause
);
   localparam int unsigned MAX_TICKS = (BASE_TICKS << (NCODES - 1)) >> REF_CODE;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   if (BASE_TICKS < 16 || (BASE_TICKS & (BASE_TICKS - 1)) != 0) begin : g_bad_base
      $error("BASE_TICKS must be a power of two of at least 16");
   end

   logic [CODE_W-1:0] code_q;
   logic              wmc_q;
   wd_mode_e          mode, mode_q;
   logic              mode_chg, cfg_chg;
   logic [CNT_W-1:0]  period, half, cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= CODE_W'(REF_CODE);
         wmc_q  <= 1'b0;
         mode_q <= WD_OFF;
      end else begin
         mode_q <= mode;
         if (wr_en) begin
            code_q <= wr_period;
            wmc_q  <= wr_wmode;
         end
      end
   end

   assign mode_chg = (mode != mode_q);
   assign cfg_chg  = wr_en && ((wr_period != code_q) || (wr_wmode != wmc_q));

   mmwd_mode_dec u_mode (
      .sys_mode (sys_mode),
      .wmode    (wmc_q),
      .mode     (mode)
   );

   mmwd_period_lut #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_lut (
      .code   (code_q),
      .period (period),
      .half   (half)
   );

   mmwd_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode),
      .mode_chg (mode_chg),
      .wr_en    (wr_en),
      .cfg_chg  (cfg_chg),
      .period   (period),
      .half     (half),
      .cnt      (cnt),
      .req      (rst_req),
      .cause    (rst_cause)
   );
endmodule

// File: rtl/mmwd_checker.sv
module mmwd_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [2:0]       sys_mode,
   input logic             wr_en,
   input logic [2:0]       wr_period,
   input logic             wr_wmode,
   input logic [2:0]       code_q,
   input logic             wmc_q,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic             rst_req,
   input logic             rst_cause
);
   // R4: any off state leaves the next cycle without a request
   assert_off_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode == 3'd0 || sys_mode == 3'd3 || sys_mode >= 3'd4 || mode == 2'd0) |=> !rst_req);

   // R5: an early-cause request always follows a write
   assert_early_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && rst_cause) |-> $past(wr_en));

   // R3: early faults come only from window mode
   assert_early_only_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && rst_cause) |-> ($past(mode) == 2'd2));

   // R6: an overflow request follows a tick with no write
   assert_overflow_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !rst_cause) |-> ($past(tick) && !$past(wr_en)));

   // R2: elapsed count stays inside the selected period
   assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period);

   // R8: config-changing writes never fault
   assert_cfg_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_period != code_q || wr_wmode != wmc_q)) |=> !rst_req);

   // R9: a mode change restarts the count and raises nothing
   assert_mode_change_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |=> (!rst_req && cnt == '0));
endmodule

bind mmwd_top mmwd_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .sys_mode  (sys_mode),
   .wr_en     (wr_en),
   .wr_period (wr_period),
   .wr_wmode  (wr_wmode),
   .code_q    (code_q),
   .wmc_q     (wmc_q),
   .mode      (mode),
   .cnt       (cnt),
   .period    (period),
   .rst_req   (rst_req),
   .rst_cause (rst_cause)
);

// File: tb/mmwd_top_tb.sv
module mmwd_top_tb;
   localparam int BASE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [2:0] sys_mode = 3'd0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_period = 3'd4;
   logic       wr_wmode = 1'b0;
   logic       rst_req, rst_cause;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   mmwd_top #(.BASE_TICKS(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sys_mode(sys_mode),
      .wr_en(wr_en), .wr_period(wr_period), .wr_wmode(wr_wmode),
      .rst_req(rst_req), .rst_cause(rst_cause)
   );

   // ---------------- behavioural reference model ----------------
   int m_cnt, m_code, m_wmc, m_prev;
   bit exp_req, exp_cause;

   function automatic int wd_of(int sm, int w);
      if (sm == 2) return w ? 1 : 2;
      if (sm == 1) return w ? 0 : 1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_code = 4; m_wmc = 0; m_prev = 0;
         exp_req = 0; exp_cause = 0;
      end else begin
         int md, per;
         md  = wd_of(int'(sys_mode), m_wmc);
         per = (BASE << m_code) >> 4;
         exp_req = 0;
         if (md == 0 || md != m_prev) m_cnt = 0;
         else if (wr_en) begin
            if (int'(wr_period) == m_code && int'(wr_wmode) == m_wmc &&
                md == 2 && m_cnt < per / 2) begin
               exp_req = 1; exp_cause = 1;
            end
            m_cnt = 0;
         end else if (tick) begin
            if (m_cnt == per - 1) begin
               exp_req = 1; exp_cause = 0; m_cnt = 0;
            end else m_cnt++;
         end
         if (wr_en) begin m_code = int'(wr_period); m_wmc = int'(wr_wmode); end
         m_prev = md;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_chk++;
         if (rst_req !== exp_req || (exp_req && rst_cause !== exp_cause)) begin
            n_fail++;
            $display("FAIL %s model: req=%b cause=%b expected req=%b cause=%b",
                     exp_req ? (exp_cause ? "R5" : "R6") : "R7",
                     rst_req, rst_cause, exp_req, exp_cause);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int code, int w);
      wr_en = 1'b1; wr_period = 3'(code); wr_wmode = w[0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_mode(int m);
      sys_mode = 3'(m);
      @(negedge clk);
   endtask

   task automatic cycles_to_req(output int n);
      n = 0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         n++;
         if (rst_req) break;
      end
   endtask

   task automatic quiet_for(string tag, int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_req) seen++;
      end
      check(tag, seen, 0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1 req after reset", rst_req, 0);

      // R1: default code gives BASE ticks in timeout (standby, bit 0)
      set_mode(1);
      cycles_to_req(n);
      check("R1 default period", n, 16);
      check("R6 overflow cause", rst_cause, 0);
      step(1);
      check("R10 pulse drops", rst_req, 0);

      // R2: period scaling
      wr(5, 0); cycles_to_req(n); check("R2 code5", n, 32);
      wr(2, 0); cycles_to_req(n); check("R2 code2", n, 4);
      wr(0, 0); cycles_to_req(n); check("R2 code0", n, 1);
      wr(4, 0);

      // R5: early strobe in window mode
      set_mode(2);
      step(3);
      wr(4, 0);
      check("R5 early req", rst_req, 1);
      check("R5 early cause", rst_cause, 1);

      // R7: strobe at half accepted, period restarts
      step(8);
      wr(4, 0);
      check("R7 late strobe quiet", rst_req, 0);
      cycles_to_req(n);
      check("R7 restart period", n, 16);

      // R8: changing write in first half is not a fault
      step(2);
      wr(5, 0);
      check("R8 cfg write quiet", rst_req, 0);
      cycles_to_req(n);
      check("R8 restarted at new period", n, 32);
      wr(4, 0);

      // R3: timeout in normal with bit 1 tolerates early strobes
      wr(4, 1);
      step(3);
      wr(4, 1);
      check("R3 timeout no early fault", rst_req, 0);
      cycles_to_req(n);
      check("R3 timeout overflow", n, 16);

      // R9: mode change mid-period restarts
      wr(4, 0);
      step(12);
      set_mode(1);
      check("R9 change quiet", rst_req, 0);
      cycles_to_req(n);
      check("R9 restart after change", n, 16);

      // R4: off states
      wr(4, 1);
      quiet_for("R4 standby bit1", 200);
      wr(4, 1);
      check("R4 write in off", rst_req, 0);
      wr(4, 0);
      set_mode(3); quiet_for("R4 sleep", 200);
      set_mode(4); quiet_for("R4 overtemp", 200);
      set_mode(0); quiet_for("R4 off", 200);
      set_mode(7); quiet_for("R4 undefined", 200);

      // R1: code returns to default after reset
      set_mode(1);
      wr(6, 0);
      set_mode(0);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      set_mode(1);
      cycles_to_req(n);
      check("R1 code restored", n, 16);

      // mixed traffic against the model
      for (int i = 0; i < 4000; i++) begin
         tick = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 199) == 0) sys_mode = ($urandom_range(0, 3) == 0) ? 3'd1 : 3'd2;
         if ($urandom_range(0, 29) == 0) begin
            wr_en = 1'b1;
            wr_period = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(3, 5)) : wr_period;
            wr_wmode  = ($urandom_range(0, 7) == 0) ? ~wr_wmode : wr_wmode;
         end else wr_en = 1'b0;
         @(negedge clk);
      end
      wr_en = 1'b0;
      step(2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule